// File: doc/BRIEF.md
# Shared-Bus Arbiter with Bus Parking

This block decides which of up to sixteen masters owns a shared on-chip bus. Each master raises a request line and receives a one-hot grant. The winner is picked either from a priority table that software writes, or from a least-recently-used order that the hardware keeps up to date. A design parameter selects between the two. Once a master holds the bus, it keeps it for as long as it keeps requesting.

When nobody requests, a control register can leave the bus "parked" on one master, so that the master starts its next transfer with no arbitration cycle. The parked master is either one that software names, or the master that last won arbitration.

A response watchdog counts the cycles of a transfer that go by without a slave acknowledge. After sixteen such cycles it pulses a timeout and takes the bus back. A small byte-wide register port gives read and write access to the priority table and the control register.

Top module: `bus_arbiter_park`

## Requirements
- R1: At most one grant bit is high in any cycle.
- R2: A granted master that keeps its request high, with no timeout, keeps the grant. When the owner's request is low at a rising edge, the grant is re-decided at that edge, and the new grant is visible from the following cycle.
- R3: The priority table is fixed and software-written when `USE_LRU`=0. Register addresses 0..N_MASTERS-1 are priority levels, and data bits [3:0] hold a master number. Level 0 wins first. After reset, level i holds master i. A level that holds a number of N_MASTERS or more never wins.
- R4: With `USE_LRU`=1, each arbitration winner moves to the last level (N_MASTERS-1) and the masters behind it each move up one level. Register writes to the levels are ignored, and reads return the current order.
- R5: The control register sits at address 16 and resets to 0. Bit 0 enables parking. Bit 1 picks the park target: 0 means the named master, 1 means the last arbitration winner. Bits [7:4] name the master, and bits [3:2] read as 0. With no request and parking disabled, or with a named master of N_MASTERS or more, no grant is given.
- R6: With parking enabled and no request at an edge, the park target is granted from the next cycle. If the parked master then raises its request, it keeps the grant with no gap and no arbitration.
- R7: If 16 consecutive cycles of a transfer pass with no `slv_ack`, `timeout` is high for exactly one cycle: the 17th cycle after the grant appeared. The bus is re-arbitrated at the next edge. An acknowledge, or a new grant, restarts the count.
- R8: A read of any unused register address (N_MASTERS..15, and 17..31) returns 0.
- R9: After reset, no grant is given and `timeout` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_MASTERS | Request, one bit per master |
| gnt | output | N_MASTERS | One-hot grant, registered |
| slv_ack | input | 1 | Slave acknowledge for the current transfer |
| timeout | output | 1 | One-cycle pulse when a transfer times out |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |

## Verification
Grants and register updates are due one clock edge after the inputs that cause them. The timeout is due in the seventeenth cycle of an unacknowledged transfer. Read data follows the address within the same cycle and shows the state after the most recent edge.

The bench drives its inputs 1 ns after each falling edge, and both the design and the behavioural model sample them at the next rising edge. The bench compares every output against the model at the falling edge, before it drives new inputs, so each result is checked in the cycle it is due. Two instances run side by side, one in fixed-priority mode and one in least-recently-used mode. A directed count confirms that the timeout arrives exactly sixteen cycles after the grant.

// File: rtl/arb_pkg.sv
// Shared constants and the control register layout for the bus arbiter.
package arb_pkg;
    localparam int ID_W      = 4;
    localparam int MAX_MST   = 16;
    localparam int REG_AW    = 5;
    localparam logic [REG_AW-1:0] CTRL_ADDR = 5'd16;

    // Control byte: [7:4] park master, [3:2] reserved (read 0), [1] park on last, [0] park enable
    typedef struct packed {
        logic [ID_W-1:0] park_id;
        logic [1:0]      rsvd;
        logic            park_last;
        logic            park_en;
    } arb_ctrl_t;
endpackage

// File: rtl/arb_order_table.sv
// Priority order table: one master number per level, level 0 first.
// Assumes N is 1..16. USE_LRU picks the variant: a software-written table,
// or a least-recently-used list that hardware rotates on each win.
module arb_order_table #(
    parameter int N       = 4,
    parameter bit USE_LRU = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [3:0]   wr_lvl,
    input  logic [3:0]   wr_id,
    input  logic         upd_en,
    input  logic [3:0]   upd_id,
    output logic [N*4-1:0] order_flat
);
    logic [3:0] ord_q [N];

    for (genvar i = 0; i < N; i++) begin : g_out
        assign order_flat[i*4 +: 4] = ord_q[i];
    end

    if (USE_LRU) begin : g_lru
        logic [3:0] ord_nxt [N];
        logic       unused_wr;
        assign unused_wr = ^{wr_en, wr_lvl, wr_id};

        // Next order: drop the winner from its level, close the gap, append it last.
        always_comb begin
            int pos;
            pos = N - 1;
            for (int i = N - 1; i >= 0; i--) begin
                if (ord_q[i] == upd_id) pos = i;
            end
            for (int i = 0; i < N - 1; i++) begin
                ord_nxt[i] = (i < pos) ? ord_q[i] : ord_q[i+1];
            end
            ord_nxt[N-1] = upd_id;
        end

        // Hold the order; reset to identity, rotate on every arbitration win.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < N; i++) ord_q[i] <= 4'(i);
            end else if (upd_en) begin
                ord_q <= ord_nxt;
            end
        end
    end else begin : g_fixed
        logic unused_upd;
        assign unused_upd = ^{upd_en, upd_id};

        // Hold the order; reset to identity, software writes one level at a time.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < N; i++) ord_q[i] <= 4'(i);
            end else if (wr_en) begin
                for (int i = 0; i < N; i++) begin
                    if (wr_lvl == 4'(i)) ord_q[i] <= wr_id;
                end
            end
        end
    end
endmodule

// File: rtl/arb_pick.sv
// Winner selection: scans the levels and returns the requesting master on
// the lowest level. Master numbers of N or more never match a request.
module arb_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]   req,
    input  logic [N*4-1:0] order_flat,
    output logic           win_vld,
    output logic [3:0]     win_id
);
    logic [15:0] req_ext;
    assign req_ext = 16'(req);

    // Walk from the last level to level 0 so that the lowest matching level is kept.
    always_comb begin
        logic [3:0] id;
        win_vld = 1'b0;
        win_id  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            id = order_flat[i*4 +: 4];
            if (req_ext[id]) begin
                win_vld = 1'b1;
                win_id  = id;
            end
        end
    end
endmodule

// File: rtl/arb_watchdog.sv
// Slave-response watchdog: counts busy cycles without an acknowledge and
// flags expiry once LIMIT of them have gone by. A restart or an ack clears it.
module arb_watchdog #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic ack,
    input  logic busy,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt_q;

    // Count unacknowledged busy cycles, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || ack) begin
            cnt_q <= '0;
        end else if (busy && cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expired = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/bus_arbiter_park.sv
// Shared-bus arbiter with parking and a response watchdog.
// Assumes 1 <= N_MASTERS <= 16. The grant is registered, and a new decision
// is made at any edge where the owner is not requesting or has timed out.
module bus_arbiter_park
    import arb_pkg::*;
#(
    parameter int N_MASTERS   = 4,
    parameter bit USE_LRU     = 1'b0,
    parameter int ACK_TIMEOUT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req,
    output logic [N_MASTERS-1:0] gnt,
    input  logic                 slv_ack,
    output logic                 timeout,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata
);
    localparam logic [4:0] N_LIM = 5'(N_MASTERS);

    arb_ctrl_t          ctrl_q;
    logic [ID_W-1:0]    owner_q, last_q, win_id, park_tgt;
    logic               own_vld_q, win_vld, busy, hold, park_ok, park_on;
    logic [15:0]        req_ext;
    logic [N_MASTERS*4-1:0] order_flat;
    logic               ctrl_we, lvl_we;

    assign req_ext  = 16'(req);
    assign busy     = own_vld_q && req_ext[owner_q];
    assign hold     = busy && !timeout;
    assign park_tgt = ctrl_q.park_last ? last_q : ctrl_q.park_id;
    assign park_ok  = ctrl_q.park_en && (5'(park_tgt) < N_LIM);
    assign park_on  = ctrl_q.park_en;
    assign ctrl_we  = reg_we && (reg_addr == CTRL_ADDR);
    assign lvl_we   = reg_we && (reg_addr < N_LIM);

    arb_order_table #(.N(N_MASTERS), .USE_LRU(USE_LRU)) u_order (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lvl_we), .wr_lvl(reg_addr[3:0]), .wr_id(reg_wdata[3:0]),
        .upd_en(!hold && win_vld), .upd_id(win_id),
        .order_flat(order_flat)
    );

    arb_pick #(.N(N_MASTERS)) u_pick (
        .req(req), .order_flat(order_flat),
        .win_vld(win_vld), .win_id(win_id)
    );

    arb_watchdog #(.LIMIT(ACK_TIMEOUT)) u_wdog (
        .clk(clk), .rst_n(rst_n),
        .restart(!hold), .ack(slv_ack), .busy(busy),
        .expired(timeout)
    );

    // Owner state: hold, hand to an arbitration winner, park, or release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q   <= '0;
            own_vld_q <= 1'b0;
            last_q    <= '0;
        end else if (!hold) begin
            if (win_vld) begin
                owner_q   <= win_id;
                own_vld_q <= 1'b1;
                last_q    <= win_id;
            end else if (park_ok) begin
                owner_q   <= park_tgt;
                own_vld_q <= 1'b1;
            end else begin
                own_vld_q <= 1'b0;
            end
        end
    end

    // Control register write; reserved bits are stored as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= '{park_id: reg_wdata[7:4], rsvd: 2'b00,
                        park_last: reg_wdata[1], park_en: reg_wdata[0]};
        end
    end

    // Decode the owner into the one-hot grant vector.
    for (genvar i = 0; i < N_MASTERS; i++) begin : g_gnt
        assign gnt[i] = own_vld_q && (owner_q == 4'(i));
    end

    // Register read mux: levels, control, zero elsewhere.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_ADDR) begin
            reg_rdata = ctrl_q;
        end else begin
            for (int i = 0; i < N_MASTERS; i++) begin
                if (reg_addr == 5'(i)) reg_rdata = {4'b0000, order_flat[i*4 +: 4]};
            end
        end
    end
endmodule

// File: rtl/arb_checker.sv
// Temporal checks on the arbiter ports, bound into every instance.
module arb_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req,
    input logic [N-1:0] gnt,
    input logic         slv_ack,
    input logic         timeout,
    input logic         park_on
);
    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R2
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(gnt & req)) && !timeout) |=> $stable(gnt));

    // R5
    no_park_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req == '0) && !park_on) |=> (gnt == '0));

    // R7
    timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    // R7
    timeout_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (gnt != '0));

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slv_ack |=> !timeout);
endmodule

bind bus_arbiter_park arb_checker #(.N(N_MASTERS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt),
    .slv_ack(slv_ack), .timeout(timeout), .park_on(park_on)
);

// File: tb/tb_bus_arbiter_park.sv
`timescale 1ns/1ps
// Behavioural reference: queue-based priority order, integer owner and counter.
module arb_ref_model #(
    parameter int N   = 4,
    parameter bit LRU = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         ack,
    input  logic         we,
    input  logic [4:0]   addr,
    input  logic [7:0]   wdata,
    output logic [N-1:0] e_gnt,
    output logic         e_tmo,
    output logic [7:0]   e_rdata
);
    int ordq[$];
    int own, last, cnt, win, tgt;
    logic [7:0] ctrl;
    bit tmo, hold;

    always @(posedge clk) begin
        if (!rst_n) begin
            ordq = {};
            for (int i = 0; i < N; i++) ordq.push_back(i);
            own = -1; last = 0; cnt = 0; ctrl = 8'h00;
        end else begin
            tmo  = (cnt == 16);
            hold = (own >= 0) && req[own] && !tmo;
            if (!hold || ack) cnt = 0;
            else if (cnt < 16) cnt++;
            if (!hold) begin
                win = -1;
                for (int l = 0; l < ordq.size(); l++) begin
                    if (ordq[l] < N && req[ordq[l]]) begin win = ordq[l]; break; end
                end
                if (win >= 0) begin
                    own = win; last = win;
                    if (LRU) begin
                        for (int l = 0; l < ordq.size(); l++) begin
                            if (ordq[l] == win) begin ordq.delete(l); break; end
                        end
                        ordq.push_back(win);
                    end
                end else if (ctrl[0]) begin
                    tgt = ctrl[1] ? last : int'(ctrl[7:4]);
                    own = (tgt < N) ? tgt : -1;
                end else begin
                    own = -1;
                end
            end
            if (we) begin
                if (addr == 5'd16) ctrl = wdata & 8'hF3;
                else if (int'(addr) < N && !LRU) ordq[addr] = int'(wdata[3:0]);
            end
        end
        e_gnt = '0;
        if (own >= 0) e_gnt[own] = 1'b1;
        e_tmo = (cnt == 16);
        e_rdata = 8'h00;
        if (addr == 5'd16) e_rdata = ctrl;
        else if (int'(addr) < N) e_rdata = 8'(ordq[addr]);
    end
endmodule

module tb_bus_arbiter_park;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic ack = 1'b1, we = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [N-1:0] gnt_f, gnt_l, eg_f, eg_l;
    logic tmo_f, tmo_l, et_f, et_l;
    logic [7:0] rd_f, rd_l, er_f, er_l;

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 0;
    string tag = "R9";

    always #10 clk = ~clk;

    bus_arbiter_park #(.N_MASTERS(N), .USE_LRU(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt_f), .slv_ack(ack),
        .timeout(tmo_f), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rd_f));
    bus_arbiter_park #(.N_MASTERS(N), .USE_LRU(1'b1)) dut_lru (
        .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt_l), .slv_ack(ack),
        .timeout(tmo_l), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rd_l));
    arb_ref_model #(.N(N), .LRU(1'b0)) m_fix (
        .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .we(we), .addr(addr),
        .wdata(wdata), .e_gnt(eg_f), .e_tmo(et_f), .e_rdata(er_f));
    arb_ref_model #(.N(N), .LRU(1'b1)) m_lru (
        .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .we(we), .addr(addr),
        .wdata(wdata), .e_gnt(eg_l), .e_tmo(et_l), .e_rdata(er_l));

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Step to 1 ns after the next falling edge: outputs of the last rising edge are settled.
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        tick();
        we = 1'b0;
    endtask

    // Every-cycle comparison against the reference model, before inputs move.
    always @(negedge clk) begin
        if (cmp_on) begin
            check({tag, " gnt fixed"}, 32'(gnt_f), 32'(eg_f));
            check({tag, " gnt lru"},   32'(gnt_l), 32'(eg_l));
            check({tag, " timeout fixed"}, 32'(tmo_f), 32'(et_f));
            check({tag, " timeout lru"},   32'(tmo_l), 32'(et_l));
            check({tag, " rdata fixed"}, 32'(rd_f), 32'(er_f));
            check({tag, " rdata lru"},   32'(rd_l), 32'(er_l));
            check("R1 onehot", 32'($onehot0(gnt_f) && $onehot0(gnt_l)), 32'd1);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    int lcg = 32'h1234_5678;
    int k;

    initial begin
        repeat (3) tick();
        cmp_on = 1;
        rst_n = 1'b1;
        tick();
        // R9 reset state
        check("R9 gnt after reset", 32'(gnt_f | gnt_l), 32'd0);
        check("R9 timeout after reset", 32'(tmo_f | tmo_l), 32'd0);
        check("R3 level0 reset value", 32'(rd_f), 32'd0);
        addr = 5'd16; tick();
        check("R5 ctrl reset value", 32'(rd_f), 32'd0);

        tag = "R3";
        req = 4'b0110; tick();
        check("R3 level order picks master1", 32'(gnt_f), 32'b0010);
        repeat (3) tick();
        check("R2 grant held", 32'(gnt_f), 32'b0010);
        tag = "R2";
        req = 4'b0100; tick();
        check("R2 rearbitrate after drop", 32'(gnt_f), 32'b0100);
        tag = "R3";
        wr(5'd0, 8'd3); wr(5'd1, 8'd2); wr(5'd2, 8'd1); wr(5'd3, 8'd0);
        addr = 5'd0; tick();
        check("R3 level0 readback", 32'(rd_f), 32'd3);
        check("R4 lru ignores level write", 32'(rd_l), 32'd0);
        req = 4'b0000; tick();
        check("R5 no park gives no grant", 32'(gnt_f | gnt_l), 32'd0);
        req = 4'b1111; tick();
        check("R3 programmed order picks master3", 32'(gnt_f), 32'b1000);
        check("R4 lru picks master0", 32'(gnt_l), 32'b0001);
        req = 4'b0000; tick();
        wr(5'd0, 8'd7);
        req = 4'b1111; tick();
        check("R3 out-of-range id skipped", 32'(gnt_f), 32'b0100);
        check("R4 lru picks master3", 32'(gnt_l), 32'b1000);

        tag = "R4";
        req = 4'b0000; tick();
        req = 4'b1111; tick();
        check("R4 lru picks master1", 32'(gnt_l), 32'b0010);
        req = 4'b1101; tick();
        check("R4 lru picks master2", 32'(gnt_l), 32'b0100);
        req = 4'b1011; tick();
        check("R4 lru picks master0", 32'(gnt_l), 32'b0001);

        tag = "R6";
        req = 4'b0000; tick();
        wr(5'd16, 8'h21);
        tick();
        check("R6 park on named master", 32'(gnt_f), 32'b0100);
        addr = 5'd16; tick();
        check("R5 ctrl readback", 32'(rd_f), 32'h21);
        req = 4'b0100; tick();
        check("R6 parked master keeps bus", 32'(gnt_f), 32'b0100);
        tick();
        check("R6 parked master still owns", 32'(gnt_f), 32'b0100);
        req = 4'b0000; tick();
        req = 4'b0001; tick();
        check("R6 other master takes bus", 32'(gnt_f), 32'b0001);
        req = 4'b0000;
        wr(5'd16, 8'h03);
        tick();
        check("R6 park on last winner", 32'(gnt_f), 32'b0001);
        tag = "R5";
        wr(5'd16, 8'h91);
        tick();
        check("R5 park id out of range", 32'(gnt_f | gnt_l), 32'd0);
        wr(5'd16, 8'h00);

        tag = "R7";
        ack = 1'b0; req = 4'b0001; tick();
        k = 0;
        while (!tmo_f && k < 40) begin tick(); k++; end
        check("R7 timeout 16 cycles after grant", 32'(k), 32'd16);
        tick();
        check("R7 timeout is one cycle", 32'(tmo_f), 32'd0);
        repeat (5) tick();
        ack = 1'b1; tick(); ack = 1'b0;
        repeat (20) tick();
        ack = 1'b1; req = 4'b0000; tick();

        tag = "R2 random";
        for (int i = 0; i < 600; i++) begin
            lcg = lcg * 1103515245 + 12345;
            req   = lcg[19:16];
            ack   = (lcg[23:21] != 3'd0) ? (i % 40 < 30) : 1'b0;
            we    = (lcg[26:24] == 3'd0);
            addr  = lcg[30:27] % 2 == 0 ? 5'd16 : 5'(lcg[29:28]);
            wdata = 8'(lcg[15:8]);
            tick();
        end
        we = 1'b0;

        tag = "R8";
        for (int a = 0; a < 32; a++) begin
            addr = 5'(a); tick();
            if (a > 16 || (a >= N && a < 16)) check("R8 unused address reads 0", 32'(rd_f | rd_l), 32'd0);
        end

        cmp_on = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule